// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit offset into a 20-bit physical address for a memory model that is split into 64 KB segments. It holds four 16-bit segment bases (code, stack, data, extra) and two 16-bit string index registers (source and destination). For each access it chooses a segment base. The choice follows a fixed rule per access kind, and a caller-supplied override can replace the default where the rule allows it. The base is shifted left by four bits, the offset is added, and the sum is cut to 20 bits.

One request is accepted in any cycle. The address and a valid strobe appear one clock later. For the two string access kinds the block uses its own index register as the offset, not the offset input. On the same clock edge it moves that index by one element (1 for byte, 2 for word), upwards when the direction input is low and downwards when it is high. The stack, data and extra bases are written through a general load port. The code base is written only through a separate far-transfer input. The index registers have their own load port.

Top module: `agu_top`

## Requirements
- R1: After reset, valid_o is 0, si_o and di_o are 0, the stack, data and extra bases are 0, and the code base holds RESET_CS (default 16'hFFFF).
- R2: A request sampled at a rising edge makes valid_o 1 after that edge, with addr_o = (base*16 + offset) mod 2^20. With no request, valid_o is 0 after the edge.
- R3: kind_i = 0 (fetch) always uses the code base with off_i. The override inputs have no effect on it.
- R4: kind_i = 1 (stack) uses the stack base by default. kind_i = 2 (data) and the unused codes 5 to 7 use the data base by default. Both use off_i.
- R5: When ovr_en_i = 1, ovr_seg_i replaces the default base for kinds 1, 2, 3 and 5 to 7. The encoding is 0 code, 1 stack, 2 data, 3 extra.
- R6: kind_i = 3 (string source) uses si_o as the offset and the data base by default. off_i is ignored.
- R7: kind_i = 4 (string destination) uses di_o as the offset and always uses the extra base. The override inputs are ignored.
- R8: A string access moves its index on the accepting edge by 1 (word_i = 0) or 2 (word_i = 1). It moves up when dir_i = 0 and down when dir_i = 1, modulo 2^16. The address uses the value before the move.
- R9: seg_ld_i writes seg_val_i into the base named by seg_sel_i (same encoding as R5). A write that names the code base is ignored.
- R10: far_ld_i writes far_cs_i into the code base.
- R11: idx_ld_i writes idx_val_i into the source index (idx_sel_i = 0) or the destination index (idx_sel_i = 1). This load takes priority over a string step on the same register in the same cycle.
- R12: A request in the same cycle as a base or index load uses the value held before that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Access request |
| kind_i | input | 3 | Access kind: 0 fetch, 1 stack, 2 data, 3 string source, 4 string destination |
| off_i | input | 16 | Offset for fetch, stack and data kinds |
| ovr_en_i | input | 1 | Segment override enable |
| ovr_seg_i | input | 2 | Override base: 0 code, 1 stack, 2 data, 3 extra |
| word_i | input | 1 | Element size for string steps: 0 byte, 1 word |
| dir_i | input | 1 | String direction: 0 up, 1 down |
| seg_ld_i | input | 1 | General base load strobe |
| seg_sel_i | input | 2 | Base to load (code ignored) |
| seg_val_i | input | 16 | Value for the general base load |
| far_ld_i | input | 1 | Code base load strobe |
| far_cs_i | input | 16 | Value for the code base |
| idx_ld_i | input | 1 | Index load strobe |
| idx_sel_i | input | 1 | Index to load: 0 source, 1 destination |
| idx_val_i | input | 16 | Value for the index load |
| addr_o | output | 20 | Physical address |
| valid_o | output | 1 | addr_o holds the result of the previous cycle's request |
| si_o | output | 16 | Current source index |
| di_o | output | 16 | Current destination index |

## Verification
The hardest cases to reach are the collisions within one cycle. One is a string step on an index while the same index is being loaded. Another is a request while the base it selects is being rewritten. A third is an index step that wraps past 0000 or FFFF. Directed sequences set both index registers next to the wrap points and then issue word and byte steps in both directions. They also fire loads and requests in the same cycle. A long run of random requests and loads follows, with the ranges for kind and override chosen so that these collisions happen often. The behavioural model is compared with the design on every cycle.

// File: rtl/agu_pkg.sv
package agu_pkg;

    typedef enum logic [2:0] {
        K_FETCH = 3'd0,
        K_STACK = 3'd1,
        K_DATA  = 3'd2,
        K_SSRC  = 3'd3,
        K_SDST  = 3'd4
    } kind_e;

    typedef enum logic [1:0] {
        SEG_CODE  = 2'd0,
        SEG_STACK = 2'd1,
        SEG_DATA  = 2'd2,
        SEG_EXTRA = 2'd3
    } seg_e;

    localparam int NUM_SEG = 4;

endpackage

// File: rtl/agu_seg_file.sv
module agu_seg_file
    import agu_pkg::*;
#(
    parameter int              SEG_W    = 16,
    parameter logic [SEG_W-1:0] RESET_CS = '1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          seg_ld,
    input  logic [1:0]                    seg_sel,
    input  logic [SEG_W-1:0]              seg_val,
    input  logic                          far_ld,
    input  logic [SEG_W-1:0]              far_cs,
    output logic [NUM_SEG-1:0][SEG_W-1:0] segs_o
);

    typedef struct packed {
        logic [NUM_SEG-1:0][SEG_W-1:0] base;
    } seg_st_t;

    seg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (far_ld) begin
            st_d.base[SEG_CODE] = far_cs;
        end
        // the code base is never written through the general port
        if (seg_ld && (seg_e'(seg_sel) != SEG_CODE)) begin
            st_d.base[seg_sel] = seg_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q                 <= '0;
            st_q.base[SEG_CODE]  <= RESET_CS;
        end else begin
            st_q <= st_d;
        end
    end

    assign segs_o = st_q.base;

endmodule

// File: rtl/agu_index_unit.sv
module agu_index_unit #(
    parameter int OFF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_src,
    input  logic             step_dst,
    input  logic             down,
    input  logic             word,
    input  logic             ld,
    input  logic             ld_sel,
    input  logic [OFF_W-1:0] ld_val,
    output logic [OFF_W-1:0] si_o,
    output logic [OFF_W-1:0] di_o
);

    typedef struct packed {
        logic [OFF_W-1:0] si;
        logic [OFF_W-1:0] di;
    } idx_st_t;

    idx_st_t          st_d, st_q;
    logic [OFF_W-1:0] stride;

    always_comb begin
        stride = word ? OFF_W'(2) : OFF_W'(1);
        st_d   = st_q;
        if (step_src) begin
            st_d.si = down ? st_q.si - stride : st_q.si + stride;
        end
        if (step_dst) begin
            st_d.di = down ? st_q.di - stride : st_q.di + stride;
        end
        // an explicit load wins over a step on the same register
        if (ld) begin
            if (ld_sel) st_d.di = ld_val;
            else        st_d.si = ld_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign si_o = st_q.si;
    assign di_o = st_q.di;

endmodule

// File: rtl/agu_addr_calc.sv
module agu_addr_calc
    import agu_pkg::*;
#(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int PA_W  = 20
) (
    input  logic [2:0]                    kind,
    input  logic [OFF_W-1:0]              off,
    input  logic                          ovr_en,
    input  logic [1:0]                    ovr_seg,
    input  logic [NUM_SEG-1:0][SEG_W-1:0] segs,
    input  logic [OFF_W-1:0]              si,
    input  logic [OFF_W-1:0]              di,
    output logic [PA_W-1:0]               paddr,
    output logic                          is_src,
    output logic                          is_dst
);

    localparam int SHIFT = PA_W - SEG_W;

    seg_e             pick;
    logic [OFF_W-1:0] eff_off;
    logic [PA_W-1:0]  base_sh;

    always_comb begin
        is_src  = 1'b0;
        is_dst  = 1'b0;
        eff_off = off;
        case (kind_e'(kind))
            K_FETCH: pick = SEG_CODE;
            K_STACK: pick = ovr_en ? seg_e'(ovr_seg) : SEG_STACK;
            K_SSRC: begin
                pick    = ovr_en ? seg_e'(ovr_seg) : SEG_DATA;
                eff_off = si;
                is_src  = 1'b1;
            end
            K_SDST: begin
                pick    = SEG_EXTRA;
                eff_off = di;
                is_dst  = 1'b1;
            end
            default: pick = ovr_en ? seg_e'(ovr_seg) : SEG_DATA;
        endcase
        base_sh = PA_W'(segs[pick]) << SHIFT;
        paddr   = base_sh + PA_W'(eff_off);
    end

endmodule

// File: rtl/agu_top.sv
module agu_top
    import agu_pkg::*;
#(
    parameter int               SEG_W    = 16,
    parameter int               OFF_W    = 16,
    parameter int               PA_W     = 20,
    parameter logic [SEG_W-1:0] RESET_CS = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [2:0]       kind_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic             ovr_en_i,
    input  logic [1:0]       ovr_seg_i,
    input  logic             word_i,
    input  logic             dir_i,
    input  logic             seg_ld_i,
    input  logic [1:0]       seg_sel_i,
    input  logic [SEG_W-1:0] seg_val_i,
    input  logic             far_ld_i,
    input  logic [SEG_W-1:0] far_cs_i,
    input  logic             idx_ld_i,
    input  logic             idx_sel_i,
    input  logic [OFF_W-1:0] idx_val_i,
    output logic [PA_W-1:0]  addr_o,
    output logic             valid_o,
    output logic [OFF_W-1:0] si_o,
    output logic [OFF_W-1:0] di_o
);

    typedef struct packed {
        logic            valid;
        logic [PA_W-1:0] addr;
    } out_st_t;

    logic [NUM_SEG-1:0][SEG_W-1:0] segs;
    logic [OFF_W-1:0]              si_q, di_q;
    logic [PA_W-1:0]               paddr;
    logic                          is_src, is_dst;
    out_st_t                       out_d, out_q;

    agu_seg_file #(.SEG_W(SEG_W), .RESET_CS(RESET_CS)) i_segs (
        .clk     (clk),
        .rst_n   (rst_n),
        .seg_ld  (seg_ld_i),
        .seg_sel (seg_sel_i),
        .seg_val (seg_val_i),
        .far_ld  (far_ld_i),
        .far_cs  (far_cs_i),
        .segs_o  (segs)
    );

    agu_addr_calc #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) i_calc (
        .kind    (kind_i),
        .off     (off_i),
        .ovr_en  (ovr_en_i),
        .ovr_seg (ovr_seg_i),
        .segs    (segs),
        .si      (si_q),
        .di      (di_q),
        .paddr   (paddr),
        .is_src  (is_src),
        .is_dst  (is_dst)
    );

    agu_index_unit #(.OFF_W(OFF_W)) i_idx (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_src (req_i & is_src),
        .step_dst (req_i & is_dst),
        .down     (dir_i),
        .word     (word_i),
        .ld       (idx_ld_i),
        .ld_sel   (idx_sel_i),
        .ld_val   (idx_val_i),
        .si_o     (si_q),
        .di_o     (di_q)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = req_i;
        if (req_i) out_d.addr = paddr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign addr_o  = out_q.addr;
    assign valid_o = out_q.valid;
    assign si_o    = si_q;
    assign di_o    = di_q;

endmodule

// File: rtl/agu_chk.sv
module agu_chk #(
    parameter int OFF_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_i,
    input logic [2:0]       kind_i,
    input logic             word_i,
    input logic             dir_i,
    input logic             idx_ld_i,
    input logic             idx_sel_i,
    input logic [OFF_W-1:0] idx_val_i,
    input logic             valid_o,
    input logic [OFF_W-1:0] si_o,
    input logic [OFF_W-1:0] di_o
);

    logic [OFF_W-1:0] stride, si_next, di_next;
    logic             src_step, dst_step;

    assign stride   = word_i ? OFF_W'(2) : OFF_W'(1);
    assign si_next  = dir_i ? si_o - stride : si_o + stride;
    assign di_next  = dir_i ? di_o - stride : di_o + stride;
    assign src_step = req_i && (kind_i == 3'd3) && !(idx_ld_i && !idx_sel_i);
    assign dst_step = req_i && (kind_i == 3'd4) && !(idx_ld_i && idx_sel_i);

    // R2
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> valid_o);

    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !valid_o);

    // R8
    src_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_step |=> (si_o == $past(si_next)));

    // R8
    dst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dst_step |=> (di_o == $past(di_next)));

    // R11
    src_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_ld_i && !idx_sel_i) |=> (si_o == $past(idx_val_i)));

    // R11
    dst_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_ld_i && idx_sel_i) |=> (di_o == $past(idx_val_i)));

    // R6
    src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idx_ld_i && !(req_i && kind_i == 3'd3)) |=> $stable(si_o));

    // R7
    dst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idx_ld_i && !(req_i && kind_i == 3'd4)) |=> $stable(di_o));

endmodule

bind agu_top agu_chk #(.OFF_W(OFF_W)) i_agu_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .kind_i    (kind_i),
    .word_i    (word_i),
    .dir_i     (dir_i),
    .idx_ld_i  (idx_ld_i),
    .idx_sel_i (idx_sel_i),
    .idx_val_i (idx_val_i),
    .valid_o   (valid_o),
    .si_o      (si_o),
    .di_o      (di_o)
);

// File: tb/test_agu_top.sv
module test_agu_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [2:0]  kind_i = '0;
    logic [15:0] off_i = '0;
    logic        ovr_en_i = 1'b0;
    logic [1:0]  ovr_seg_i = '0;
    logic        word_i = 1'b0;
    logic        dir_i = 1'b0;
    logic        seg_ld_i = 1'b0;
    logic [1:0]  seg_sel_i = '0;
    logic [15:0] seg_val_i = '0;
    logic        far_ld_i = 1'b0;
    logic [15:0] far_cs_i = '0;
    logic        idx_ld_i = 1'b0;
    logic        idx_sel_i = 1'b0;
    logic [15:0] idx_val_i = '0;
    logic [19:0] addr_o;
    logic        valid_o;
    logic [15:0] si_o, di_o;

    always #2 clk = ~clk;

    agu_top i_agu_top (.*);

    int    checks = 0;
    int    failures = 0;
    int    cycles = 0;
    bit    done = 1'b0;
    string phase = "R1";

    // behavioural reference
    int unsigned m_seg [4];
    int unsigned m_si, m_di, m_addr;
    bit          m_valid;

    always @(posedge clk) begin
        int unsigned s, o, st, nsi, ndi;
        int unsigned nseg [4];
        if (!rst_n) begin
            m_seg = '{32'hFFFF, 0, 0, 0};
            m_si = 0; m_di = 0; m_addr = 0; m_valid = 0;
        end else begin
            nseg = m_seg; nsi = m_si; ndi = m_di;
            st = word_i ? 2 : 1;
            m_valid = req_i;
            if (req_i) begin
                o = off_i;
                case (kind_i)
                    3'd0: s = 0;
                    3'd1: s = ovr_en_i ? ovr_seg_i : 1;
                    3'd3: begin
                        s = ovr_en_i ? ovr_seg_i : 2;
                        o = m_si;
                        nsi = (m_si + (dir_i ? 65536 - st : st)) % 65536;
                    end
                    3'd4: begin
                        s = 3;
                        o = m_di;
                        ndi = (m_di + (dir_i ? 65536 - st : st)) % 65536;
                    end
                    default: s = ovr_en_i ? ovr_seg_i : 2;
                endcase
                m_addr = (m_seg[s] * 16 + o) % (1 << 20);
            end
            if (far_ld_i) nseg[0] = far_cs_i;
            if (seg_ld_i && seg_sel_i != 0) nseg[seg_sel_i] = seg_val_i;
            if (idx_ld_i) begin
                if (idx_sel_i) ndi = idx_val_i;
                else           nsi = idx_val_i;
            end
            m_seg = nseg; m_si = nsi; m_di = ndi;
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (valid_o !== m_valid) begin
                failures++;
                $display("FAIL %s valid_o actual=%0b expected=%0b", phase, valid_o, m_valid);
            end else if (m_valid && addr_o !== 20'(m_addr)) begin
                failures++;
                $display("FAIL %s addr_o actual=%05h expected=%05h", phase, addr_o, m_addr);
            end else if (si_o !== 16'(m_si)) begin
                failures++;
                $display("FAIL %s si_o actual=%04h expected=%04h", phase, si_o, m_si);
            end else if (di_o !== 16'(m_di)) begin
                failures++;
                $display("FAIL %s di_o actual=%04h expected=%04h", phase, di_o, m_di);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic idle();
        req_i = 0; ovr_en_i = 0; seg_ld_i = 0; far_ld_i = 0; idx_ld_i = 0;
    endtask

    task automatic tick();
        @(negedge clk);
        idle();
    endtask

    task automatic acc(input logic [2:0] k, input logic [15:0] o,
                       input logic oe, input logic [1:0] os,
                       input logic w, input logic d);
        req_i = 1; kind_i = k; off_i = o; ovr_en_i = oe; ovr_seg_i = os;
        word_i = w; dir_i = d;
        tick();
    endtask

    task automatic segld(input logic [1:0] sel, input logic [15:0] v);
        seg_ld_i = 1; seg_sel_i = sel; seg_val_i = v;
        tick();
    endtask

    task automatic farld(input logic [15:0] v);
        far_ld_i = 1; far_cs_i = v;
        tick();
    endtask

    task automatic idxld(input logic sel, input logic [15:0] v);
        idx_ld_i = 1; idx_sel_i = sel; idx_val_i = v;
        tick();
    endtask

    initial begin
        phase = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: code base resets to FFFF, FFFF0+0010 wraps to 00000
        acc(3'd0, 16'h0010, 0, 0, 0, 0);
        acc(3'd1, 16'h0020, 0, 0, 0, 0);
        tick();

        phase = "R10";
        farld(16'h1234);
        phase = "R3";
        acc(3'd0, 16'h0010, 1, 2'd3, 0, 0);
        acc(3'd0, 16'hFFFF, 1, 2'd1, 0, 0);

        phase = "R9";
        segld(2'd1, 16'h2000);
        segld(2'd2, 16'h3000);
        segld(2'd3, 16'h4000);
        segld(2'd0, 16'hAAAA);
        acc(3'd0, 16'h0001, 0, 0, 0, 0);

        phase = "R4";
        acc(3'd1, 16'h0100, 0, 0, 0, 0);
        acc(3'd2, 16'h0200, 0, 0, 0, 0);
        acc(3'd6, 16'h0300, 0, 0, 0, 0);
        segld(2'd2, 16'hFFFF);
        acc(3'd2, 16'hFFFF, 0, 0, 0, 0);

        phase = "R5";
        acc(3'd2, 16'h0004, 1, 2'd3, 0, 0);
        acc(3'd1, 16'h0008, 1, 2'd0, 0, 0);
        acc(3'd7, 16'h000C, 1, 2'd1, 0, 0);

        phase = "R11";
        idxld(0, 16'h0001);
        idxld(1, 16'hFFFF);

        phase = "R6";
        acc(3'd3, 16'h7777, 0, 0, 0, 0);
        acc(3'd3, 16'h7777, 1, 2'd3, 1, 0);

        phase = "R8";
        acc(3'd3, 16'h0, 0, 0, 1, 1);
        acc(3'd3, 16'h0, 0, 0, 1, 1);
        acc(3'd3, 16'h0, 0, 0, 0, 1);
        acc(3'd4, 16'h0, 0, 0, 0, 0);
        acc(3'd4, 16'h0, 0, 0, 1, 1);
        acc(3'd4, 16'h0, 0, 0, 1, 1);

        phase = "R7";
        acc(3'd4, 16'h5555, 1, 2'd2, 1, 0);

        phase = "R12";
        req_i = 1; kind_i = 3'd2; off_i = 16'h0010; ovr_en_i = 0;
        seg_ld_i = 1; seg_sel_i = 2'd2; seg_val_i = 16'h0800;
        tick();
        req_i = 1; kind_i = 3'd0; off_i = 16'h0002;
        far_ld_i = 1; far_cs_i = 16'h0F00;
        tick();
        acc(3'd0, 16'h0002, 0, 0, 0, 0);
        phase = "R11";
        req_i = 1; kind_i = 3'd3; word_i = 1; dir_i = 0;
        idx_ld_i = 1; idx_sel_i = 0; idx_val_i = 16'h0100;
        tick();
        acc(3'd3, 16'h0, 0, 0, 0, 0);

        phase = "R2";
        for (int i = 0; i < 400; i++) begin
            req_i     = $urandom_range(0, 3) != 0;
            kind_i    = 3'($urandom_range(0, 7));
            off_i     = 16'($urandom);
            ovr_en_i  = $urandom_range(0, 1) == 1;
            ovr_seg_i = 2'($urandom);
            word_i    = $urandom_range(0, 1) == 1;
            dir_i     = $urandom_range(0, 1) == 1;
            seg_ld_i  = $urandom_range(0, 5) == 0;
            seg_sel_i = 2'($urandom);
            seg_val_i = 16'($urandom);
            far_ld_i  = $urandom_range(0, 7) == 0;
            far_cs_i  = 16'($urandom);
            idx_ld_i  = $urandom_range(0, 5) == 0;
            idx_sel_i = $urandom_range(0, 1) == 1;
            idx_val_i = 16'($urandom_range(0, 3)) + (($urandom_range(0, 1) == 1) ? 16'hFFFC : 16'h0);
            tick();
        end
        tick();
        tick();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule